// File: doc/BRIEF.md
# Prioritized Interrupt State Vector Unit

This block gathers the interrupt events of a serial-bus data-link controller and condenses them into one read-only byte. Each event input is a one-cycle pulse that latches a sticky pending flag. The flag stays set until a per-source acknowledge strobe clears it. The acknowledge stands in for whatever action software takes to service that source.

The byte always names the single most urgent pending source. Its 4-bit code sits at bits 5..2, so the value steps by four and can be added straight to the base of a jump table. When the reported source is serviced, the next lower pending source appears. The byte falls back to zero only when nothing is left pending.

The block also drives a combined interrupt request, which an enable input can mask, and exposes the raw pending flags. A register-read port returns the vector. Any write through that port is discarded.

Top module: `ivec_top`

## Requirements
- R1: During and right after reset the vector, the read data, the pending flags and the request output are all zero.
- R2: Event input bit i has priority i+1 and vector code i+1. The bit order is: bit 0 end-of-frame, bit 1 in-frame-response byte, bit 2 receive full, bit 3 transmit empty, bit 4 arbitration loss, bit 5 CRC error, bit 6 bad symbol, bit 7 wakeup. The code appears at vector bits 5..2, and vector bits 7, 6, 1 and 0 read zero.
- R3: A pulse on an event input sets that source's pending flag on the next edge. The flag stays set across idle cycles until it is acknowledged.
- R4: An acknowledge clears its flag on the next edge. If the set pulse and the acknowledge arrive in the same cycle for one source, the flag ends up set.
- R5: With several flags pending, the vector holds the code of the highest-priority one.
- R6: When the reported source is cleared while lower sources remain pending, the vector changes to the code of the highest of those remaining.
- R7: The vector is zero if and only if no flag was pending one cycle earlier.
- R8: The vector is registered. It reflects the pending flags as they stood one clock earlier.
- R9: The request output is high exactly when some flag is pending and the enable input is high. A low enable leaves the vector unaffected.
- R10: The read port always returns the current vector. A write strobe, with any data, changes neither the flags nor the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | 8 | One-cycle event pulses, bit i = priority i+1 |
| evt_ack | input | 8 | Per-source acknowledge strobes |
| irq_en | input | 1 | Request enable |
| bus_wr_en | input | 1 | Register write strobe (ignored) |
| bus_wr_data | input | 8 | Register write data (ignored) |
| bus_rd_data | output | 8 | Register read data (the vector) |
| vec_out | output | 8 | State vector |
| irq | output | 1 | Combined interrupt request |
| pending | output | 8 | Sticky pending flags |

## Verification
The hardest behaviour to reach is the walk down the priority ladder. Three sources must be pending together, and then the top one is serviced while the others stay latched, so that each lower code surfaces in turn. The stimulus raises several event bits in one cycle and leaves them idle for some cycles. It then acknowledges the reported source one at a time. On every cycle a scoreboard model predicts the registered vector from the flags of the previous cycle. The same-cycle set and acknowledge collision is driven on a flag that is already pending, and again on one that is clear.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
   // Number of event sources handled by the default build
   localparam int unsigned IVEC_NUM_SRC  = 8;
   // Width of the vector register
   localparam int unsigned IVEC_VEC_W    = 8;
   // Bit position where the source code starts (steps of four)
   localparam int unsigned IVEC_CODE_LSB = 2;

   // Encoder scan order selector
   typedef enum logic {
      SCAN_HIGH_IDX_WINS = 1'b0,
      SCAN_LOW_IDX_WINS  = 1'b1
   } ivec_scan_e;

   // Bits needed to encode sources plus the idle code zero
   function automatic int unsigned code_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/ivec_pend_bank.sv
module ivec_pend_bank #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] ack_i,
   output logic [NUM_SRC-1:0] pend_o
);

   generate
      if (NUM_SRC < 1) begin : g_bad_count
         $error("ivec_pend_bank: NUM_SRC must be at least one");
      end
   endgenerate

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
      logic flag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (set_i[g]) begin
            flag_q <= 1'b1;          // set dominates a same-cycle ack
         end else if (ack_i[g]) begin
            flag_q <= 1'b0;
         end
      end

      assign pend_o[g] = flag_q;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> pend_o[g]);                                      // R4
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_i[g] && !set_i[g]) |=> !pend_o[g]);                      // R4
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_i[g] && !ack_i[g]) |=> $stable(pend_o[g]));             // R3
   end

endmodule

// File: rtl/ivec_prio_enc.sv
module ivec_prio_enc
   import ivec_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter ivec_scan_e  SCAN    = SCAN_HIGH_IDX_WINS,
   localparam int unsigned CODE_W = code_width(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] pend_i,
   output logic [CODE_W-1:0]  code_o,
   output logic               any_o
);

   generate
      if (SCAN == SCAN_HIGH_IDX_WINS) begin : g_high_wins
         // later (higher index) hits overwrite earlier ones
         always_comb begin
            code_o = '0;
            for (int i = 0; i < NUM_SRC; i++) begin
               if (pend_i[i]) code_o = CODE_W'(i + 1);
            end
         end

         // R5: nothing above the reported source may be pending
         always_comb begin
            AST_NOTHING_ABOVE: assert ((pend_i >> code_o) == '0);       // R5
         end
      end else begin : g_low_wins
         // earlier (lower index) hits overwrite later ones
         always_comb begin
            code_o = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
               if (pend_i[i]) code_o = CODE_W'(i + 1);
            end
         end
      end
   endgenerate

   assign any_o = |pend_i;

endmodule

// File: rtl/ivec_top.sv
module ivec_top
   import ivec_pkg::*;
#(
   parameter int unsigned NUM_SRC    = IVEC_NUM_SRC,
   parameter int unsigned VEC_W      = IVEC_VEC_W,
   parameter int unsigned CODE_LSB   = IVEC_CODE_LSB,
   parameter bit          REG_VECTOR = 1'b1,
   parameter ivec_scan_e  SCAN       = SCAN_HIGH_IDX_WINS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_set,
   input  logic [NUM_SRC-1:0] evt_ack,
   input  logic               irq_en,
   input  logic               bus_wr_en,
   input  logic [VEC_W-1:0]   bus_wr_data,
   output logic [VEC_W-1:0]   bus_rd_data,
   output logic [VEC_W-1:0]   vec_out,
   output logic               irq,
   output logic [NUM_SRC-1:0] pending
);

   localparam int unsigned CODE_W = code_width(NUM_SRC);

   generate
      if (CODE_LSB + CODE_W > VEC_W) begin : g_bad_fit
         $error("ivec_top: code field does not fit in the vector");
      end
   endgenerate

   logic [CODE_W-1:0] code;
   logic              any_pend;
   logic [VEC_W-1:0]  vec_d;
   logic              unused_wr;

   // write port is accepted and discarded
   assign unused_wr = bus_wr_en ^ (^bus_wr_data);

   ivec_pend_bank #(
      .NUM_SRC (NUM_SRC)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_set),
      .ack_i  (evt_ack),
      .pend_o (pending)
   );

   ivec_prio_enc #(
      .NUM_SRC (NUM_SRC),
      .SCAN    (SCAN)
   ) u_enc (
      .pend_i (pending),
      .code_o (code),
      .any_o  (any_pend)
   );

   always_comb begin
      vec_d = '0;
      vec_d[CODE_LSB +: CODE_W] = code;
   end

   generate
      if (REG_VECTOR) begin : g_reg_vec
         logic [VEC_W-1:0] vec_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vec_q <= '0;
            else        vec_q <= vec_d;
         end

         assign vec_out = vec_q;

         AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (pending == '0) |=> (vec_out == '0));                       // R7
         AST_BUSY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (pending != '0) |=> (vec_out != '0));                       // R7
         AST_MASK_KEEPS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_en && pending != '0) |=> (bus_rd_data != '0));         // R9
      end else begin : g_comb_vec
         assign vec_out = vec_d;
      end
   endgenerate

   assign bus_rd_data = vec_out;
   assign irq         = any_pend & irq_en;

   AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && evt_set == '0 && evt_ack == '0) |=> $stable(pending)); // R10
   AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pending != '0));                                         // R9

endmodule

// File: tb/tb_ivec_top.sv
module tb_ivec_top;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] evt_set = '0;
   logic [7:0] evt_ack = '0;
   logic       irq_en = 1'b1;
   logic       bus_wr_en = 1'b0;
   logic [7:0] bus_wr_data = '0;
   logic [7:0] bus_rd_data;
   logic [7:0] vec_out;
   logic       irq;
   logic [7:0] pending;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] exp_pend = '0;
   logic [7:0] q_vec[$];
   logic       q_irq[$];
   logic [7:0] q_pend[$];
   string      q_tag[$];

   always #(CLK_P/2) clk = ~clk;

   ivec_top dut (
      .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_ack(evt_ack),
      .irq_en(irq_en), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
      .bus_rd_data(bus_rd_data), .vec_out(vec_out), .irq(irq),
      .pending(pending)
   );

   function automatic logic [7:0] model_vec(input logic [7:0] p);
      for (int i = 7; i >= 0; i--) begin
         if (p[i]) return 8'((i + 1) * 4);
      end
      return 8'h00;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input logic [7:0] s, input logic [7:0] a,
                       input logic en, input logic wr, input logic [7:0] wd,
                       input string tag);
      logic [7:0] nxt;
      @(negedge clk);
      evt_set = s; evt_ack = a; irq_en = en; bus_wr_en = wr; bus_wr_data = wd;
      nxt = (exp_pend & ~a) | s;
      q_vec.push_back(model_vec(exp_pend));   // registered: previous flags (R8)
      q_irq.push_back((|nxt) & en);
      q_pend.push_back(nxt);
      q_tag.push_back(tag);
      exp_pend = nxt;
      @(posedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(8'h00, 8'h00, 1'b1, 1'b0, 8'h00, tag);
   endtask

   // monitor: compares outputs after each edge against queued expectations
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (q_vec.size() > 0) begin
            logic [7:0] ev; logic ei; logic [7:0] ep; string t;
            ev = q_vec.pop_front(); ei = q_irq.pop_front();
            ep = q_pend.pop_front(); t = q_tag.pop_front();
            chk(vec_out == ev, {t, " vector"}, vec_out, ev);
            chk(bus_rd_data == ev, {t, " read port R10"}, bus_rd_data, ev);
            chk(irq == ei, {t, " request R9"}, irq, ei);
            chk(pending == ep, {t, " flags R3"}, pending, ep);
            chk((vec_out & 8'hC3) == 8'h00, {t, " reserved bits R2"}, vec_out, 0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: values while reset is held
      chk(vec_out == 8'h00, "R1 vector in reset", vec_out, 0);
      chk(pending == 8'h00, "R1 flags in reset", pending, 0);
      chk(irq == 1'b0, "R1 request in reset", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_rd_data == 8'h00, "R1 read after reset", bus_rd_data, 0);

      // R2 R3 R4: each source alone, held idle, then acknowledged
      for (int i = 0; i < 8; i++) begin
         step(8'(1 << i), 8'h00, 1'b1, 1'b0, 8'h00, "R2 single source");
         idle(2, "R3 sticky hold");
         step(8'h00, 8'(1 << i), 1'b1, 1'b0, 8'h00, "R4 ack clears");
         idle(1, "R7 back to zero");
      end

      // R5 R6 R7: three sources together, serviced from the top down
      step(8'h89, 8'h00, 1'b1, 1'b0, 8'h00, "R5 multi set");
      idle(2, "R5 highest reported");
      step(8'h00, 8'h80, 1'b1, 1'b0, 8'h00, "R6 ack wakeup");
      idle(1, "R6 next lower");
      step(8'h00, 8'h08, 1'b1, 1'b0, 8'h00, "R6 ack tx empty");
      idle(1, "R6 lowest left");
      step(8'h00, 8'h01, 1'b1, 1'b0, 8'h00, "R7 ack last");
      idle(2, "R7 all clear");

      // R5: a lower source arriving later does not displace a higher one
      step(8'h20, 8'h00, 1'b1, 1'b0, 8'h00, "R5 crc first");
      step(8'h02, 8'h00, 1'b1, 1'b0, 8'h00, "R5 lower later");
      step(8'h40, 8'h00, 1'b1, 1'b0, 8'h00, "R5 higher later");
      idle(1, "R5 settle");

      // R4: set and ack collide on a pending flag and on a clear one
      step(8'h40, 8'h40, 1'b1, 1'b0, 8'h00, "R4 collide pending");
      step(8'h04, 8'h04, 1'b1, 1'b0, 8'h00, "R4 collide clear");
      idle(1, "R4 settle");

      // R9: masked request, vector still reports
      step(8'h00, 8'h00, 1'b0, 1'b0, 8'h00, "R9 masked");
      idle(1, "R9 unmasked again");
      step(8'h00, 8'h00, 1'b0, 1'b0, 8'h00, "R9 masked vector kept");

      // R10: writes of various data change nothing
      step(8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, "R10 write ones");
      step(8'h00, 8'h00, 1'b1, 1'b1, 8'h00, "R10 write zeros");
      step(8'h00, 8'h00, 1'b1, 1'b1, 8'hA5, "R10 write pattern");
      idle(1, "R10 after writes");

      // clear everything, then a wakeup with masked request
      step(8'h00, 8'hFF, 1'b1, 1'b0, 8'h00, "R7 clear all");
      idle(1, "R7 zero again");
      step(8'h80, 8'h00, 1'b0, 1'b0, 8'h00, "R9 masked wakeup");
      idle(2, "R8 one cycle lag");
      step(8'h00, 8'h80, 1'b1, 1'b0, 8'h00, "R4 final ack");
      idle(2, "R7 final");

      @(negedge clk);
      chk(q_vec.size() == 0, "scoreboard drained", q_vec.size(), 0);
      report();
      done = 1'b1;
      $finish;
   end
endmodule